// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank and Power Tracking

This block sits on the device side of a DDR2-style SDRAM command interface and runs on one clock. On every rising edge it samples chip select, the three command strobes, the bank address, the row/column address bus and clock enable. From these it decodes the command and keeps per-bank state. Each of the four banks is either idle or open, and each open bank holds the row it was opened with. The block also tracks the power state: running, power-down with every bank idle, or power-down with a row still open.

Each accepted command comes out one cycle later as a registered strobe. With it come the command kind, target bank and address field. Reads and writes also carry their auto-precharge flag and the row their bank holds. Mode-set commands also report which mode register they select. Commands that break the bank protocol are not strobed, and neither is a clock-enable drop during a data access. Each of these raises a one-cycle violation flag instead. Other logic uses the strobe to start access sequencing, and it watches the violation flag to detect a misbehaving controller.

Top module: `sdcmd_tracker`

## Requirements
- R1: Inputs are sampled only on the rising clock edge. Every output is registered, so the effect of a command sampled at one edge is visible just after that edge.
- R2: When chip select (`cs_n`) is sampled high, the command is masked. No strobe is produced and no bank state changes.
- R3: The code {cs_n,ras_n,cas_n,we_n} is decoded as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode-set, 0111 no-op. Code 0110 is treated as no-op. `cmd_kind` reports these values: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode-set. For every strobed command `cmd_bank` equals `ba` and `cmd_addr` equals `addr`. All command outputs are zero when there is no strobe.
- R4: An activate to an idle bank opens that bank (`bank_open[ba]` set) and stores `addr` as its row.
- R5: A read or write to an open bank reports `addr[10]` on `cmd_ap` and the bank's stored row on `acc_row`. When `addr[10]` is 1, the bank becomes idle at that same edge.
- R6: A precharge reports `addr[10]` on `cmd_ap`. It closes only bank `ba` when `addr[10]` is 0, and all banks when `addr[10]` is 1.
- R7: A mode-set reports `ba` on `mr_sel` and the address bus on `cmd_addr`. `mr_sel` is 0 for every other command.
- R8: `cke` sampled low in the running state enters power-down. With all banks idle the state becomes precharge power-down (`pwr_state`=1). With any bank open it becomes active power-down (`pwr_state`=2). Running is `pwr_state`=0.
- R9: In either power-down state all commands are ignored and bank state and stored rows are kept. `cke` sampled high returns to running, and the command sampled at that exit edge is also ignored.
- R10: A read or write starts an access covering the next ACC_CYC sample edges (default 4). If `cke` is sampled low on any of them, `viol` is raised, the command is ignored and power-down is not entered.
- R11: A read or write to an idle bank, or an activate to an open bank, raises `viol`, is not strobed and leaves all bank state and rows unchanged.
- R12: A synchronous active-high reset makes every bank idle, sets the running state and clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 14 | Row/column/opcode bus; bit 10 is auto-precharge or all-bank select |
| cmd_stb | output | 1 | One-cycle strobe for an accepted command |
| cmd_kind | output | 3 | Decoded command kind |
| cmd_bank | output | 2 | Target bank |
| cmd_addr | output | 14 | Row, column or opcode |
| cmd_ap | output | 1 | Auto-precharge (read/write) or all-bank (precharge) |
| acc_row | output | 14 | Open row of the bank hit by a read or write |
| mr_sel | output | 2 | Mode register selected by a mode-set |
| viol | output | 1 | One-cycle protocol violation flag |
| bank_open | output | 4 | Per-bank open flags |
| pwr_state | output | 2 | 0 running, 1 precharge power-down, 2 active power-down |

## Verification
The hardest situation to reach is a clock-enable drop that lands inside a data access. To hit it, the stimulus opens a bank, issues a write with auto-precharge, and lowers `cke` on the very next edge. It then checks that power-down was refused even though every bank is idle by then. A second hard point is proving that a row survives active power-down. For this the stimulus opens a bank, enters power-down with it open, and offers a conflicting command inside power-down and another on the exit edge. After exit, a read reports the original row on `acc_row`. Every expected value comes from a separate bench model of the bank and power state, kept in a scoreboard queue.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        K_NOP = 3'd0,
        K_ACT = 3'd1,
        K_RD  = 3'd2,
        K_WR  = 3'd3,
        K_PRE = 3'd4,
        K_REF = 3'd5,
        K_MRS = 3'd6
    } cmd_kind_e;

    typedef enum logic [1:0] {
        P_RUN    = 2'd0,
        P_PRE_PD = 2'd1,
        P_ACT_PD = 2'd2
    } pwr_e;

    function automatic cmd_kind_e decode_code(input logic [3:0] code);
        cmd_kind_e k;
        case (code)
            4'b0011: k = K_ACT;
            4'b0101: k = K_RD;
            4'b0100: k = K_WR;
            4'b0010: k = K_PRE;
            4'b0001: k = K_REF;
            4'b0000: k = K_MRS;
            default: k = K_NOP;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int AP_BIT = 10
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_kind_e         kind,
    output logic              is_access,
    output logic              ap_bit
);
    always_comb begin
        kind      = decode_code({cs_n, ras_n, cas_n, we_n});
        is_access = (kind == K_RD) || (kind == K_WR);
        ap_bit    = addr[AP_BIT];
    end
endmodule

// File: rtl/sdcmd_bank_file.sv
module sdcmd_bank_file #(
    parameter int BANKS  = 4,
    parameter int ADDR_W = 14
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [BANKS-1:0]             set_en,
    input  logic [BANKS-1:0]             clr_en,
    input  logic [ADDR_W-1:0]            row_in,
    output logic [BANKS-1:0]             open_q,
    output logic [BANKS-1:0][ADDR_W-1:0] row_q
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[g] <= 1'b0;
                row_q[g]  <= '0;
            end else if (set_en[g]) begin
                open_q[g] <= 1'b1;
                row_q[g]  <= row_in;
            end else if (clr_en[g]) begin
                open_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdcmd_power.sv
module sdcmd_power
    import sdcmd_pkg::*;
#(
    parameter int ACC_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic any_open,
    input  logic acc_start,
    output pwr_e pwr,
    output logic accept,
    output logic cke_viol
);
    localparam int CNT_W = $clog2(ACC_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CYC);

    logic [CNT_W-1:0] busy_cnt;
    logic             busy;

    always_comb begin
        busy     = (busy_cnt != '0);
        accept   = (pwr == P_RUN) && cke;
        cke_viol = (pwr == P_RUN) && !cke && busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr      <= P_RUN;
            busy_cnt <= '0;
        end else begin
            if (acc_start)
                busy_cnt <= CNT_LOAD;
            else if (busy)
                busy_cnt <= busy_cnt - 1'b1;

            case (pwr)
                P_RUN: if (!cke && !busy) pwr <= any_open ? P_ACT_PD : P_PRE_PD;
                default: if (cke) pwr <= P_RUN;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int BANKS   = 4,
    parameter int ADDR_W  = 14,
    parameter int AP_BIT  = 10,
    parameter int ACC_CYC = 4,
    localparam int BA_W   = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_stb,
    output logic [2:0]        cmd_kind,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ap,
    output logic [ADDR_W-1:0] acc_row,
    output logic [BA_W-1:0]   mr_sel,
    output logic              viol,
    output logic [BANKS-1:0]  bank_open,
    output logic [1:0]        pwr_state
);
    cmd_kind_e                   kind;
    logic                        is_access, ap_bit;
    pwr_e                        pwr;
    logic                        accept, cke_viol;
    logic [BANKS-1:0][ADDR_W-1:0] rows;
    logic [BANKS-1:0]            set_en, clr_en, ba_hot;
    logic                        hit_open, legal, go, reject, acc_start;

    sdcmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .kind(kind), .is_access(is_access), .ap_bit(ap_bit)
    );

    sdcmd_bank_file #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_banks (
        .clk(clk), .rst(rst), .set_en(set_en), .clr_en(clr_en),
        .row_in(addr), .open_q(bank_open), .row_q(rows)
    );

    sdcmd_power #(.ACC_CYC(ACC_CYC)) u_pwr (
        .clk(clk), .rst(rst), .cke(cke), .any_open(|bank_open),
        .acc_start(acc_start), .pwr(pwr), .accept(accept), .cke_viol(cke_viol)
    );

    always_comb begin
        ba_hot   = '0;
        ba_hot[ba] = 1'b1;
        hit_open = bank_open[ba];
        case (kind)
            K_ACT:      legal = !hit_open;
            K_RD, K_WR: legal = hit_open;
            default:    legal = 1'b1;
        endcase
        go        = accept && (kind != K_NOP) && legal;
        reject    = accept && (kind != K_NOP) && !legal;
        acc_start = go && is_access;
        set_en    = (go && kind == K_ACT) ? ba_hot : '0;
        clr_en    = '0;
        if (go && kind == K_PRE)
            clr_en = ap_bit ? '1 : ba_hot;
        else if (acc_start && ap_bit)
            clr_en = ba_hot;
    end

    assign pwr_state = pwr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_stb  <= 1'b0;
            cmd_kind <= K_NOP;
            cmd_bank <= '0;
            cmd_addr <= '0;
            cmd_ap   <= 1'b0;
            acc_row  <= '0;
            mr_sel   <= '0;
            viol     <= 1'b0;
        end else begin
            cmd_stb  <= go;
            cmd_kind <= go ? kind : K_NOP;
            cmd_bank <= go ? ba : '0;
            cmd_addr <= go ? addr : '0;
            cmd_ap   <= go && (is_access || kind == K_PRE) && ap_bit;
            acc_row  <= acc_start ? rows[ba] : '0;
            mr_sel   <= (go && kind == K_MRS) ? ba : '0;
            viol     <= reject || cke_viol;
        end
    end
endmodule

// File: rtl/sdcmd_tracker_chk.sv
module sdcmd_tracker_chk #(
    parameter int BANKS = 4,
    localparam int BA_W = $clog2(BANKS)
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             cmd_stb,
    input logic [2:0]       cmd_kind,
    input logic [BA_W-1:0]  cmd_bank,
    input logic             cmd_ap,
    input logic             viol,
    input logic [BANKS-1:0] bank_open,
    input logic [1:0]       pwr_state
);
    p_cs_mask_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !cmd_stb);

    p_act_opens_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_kind == 3'd1) |-> bank_open[cmd_bank]);

    p_pre_all_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_kind == 3'd4 && cmd_ap) |-> (bank_open == '0));

    p_ppd_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd1) |-> (bank_open == '0));

    p_pd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != 2'd0) |=> (!cmd_stb && $stable(bank_open)));

    p_viol_nostb_r11: assert property (@(posedge clk) disable iff (rst)
        viol |-> (!cmd_stb && $stable(bank_open)));
endmodule

bind sdcmd_tracker sdcmd_tracker_chk #(.BANKS(BANKS)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .viol(viol),
    .bank_open(bank_open), .pwr_state(pwr_state)
);

// File: tb/sdcmd_tracker_test.sv
`timescale 1ns/1ps
module sdcmd_tracker_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [13:0] addr = '0;
    logic        cmd_stb, cmd_ap, viol;
    logic [2:0]  cmd_kind;
    logic [1:0]  cmd_bank, mr_sel, pwr_state;
    logic [13:0] cmd_addr, acc_row;
    logic [3:0]  bank_open;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sdcmd_tracker uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_stb(cmd_stb), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .acc_row(acc_row),
        .mr_sel(mr_sel), .viol(viol), .bank_open(bank_open), .pwr_state(pwr_state)
    );

    // bench model
    logic        m_open [4];
    logic [13:0] m_row  [4];
    int          m_pwr;
    int          m_busy;

    logic [43:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [43:0] pack(logic s, logic [2:0] k, logic [1:0] b,
            logic [13:0] a, logic ap, logic [13:0] r, logic [1:0] m, logic v,
            logic [3:0] o, logic [1:0] p);
        return {s, k, b, a, ap, r, m, v, o, p};
    endfunction

    function automatic logic [3:0] m_open_vec();
        return {m_open[3], m_open[2], m_open[1], m_open[0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_row[i] = '0; end
        m_pwr = 0;
        m_busy = 0;
    endtask

    task automatic check(string tag, logic [43:0] act, logic [43:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic k, logic [3:0] code, logic [1:0] b, logic [13:0] a, string tag);
        logic s, ap, v;
        logic [2:0] kind;
        logic [13:0] ea, r;
        logic [1:0] eb, m;
        logic legal, acc;
        @(negedge clk);
        cke = k; {cs_n, ras_n, cas_n, we_n} = code; ba = b; addr = a;
        s = 0; kind = 0; ea = 0; eb = 0; ap = 0; r = 0; m = 0; v = 0; acc = 0;
        if (m_pwr == 0) begin
            if (!k) begin
                if (m_busy > 0) v = 1;
                else m_pwr = (m_open_vec() != 0) ? 2 : 1;
            end else begin
                case (code)
                    4'b0011: kind = 1;
                    4'b0101: kind = 2;
                    4'b0100: kind = 3;
                    4'b0010: kind = 4;
                    4'b0001: kind = 5;
                    4'b0000: kind = 6;
                    default: kind = 0;
                endcase
                legal = (kind == 1) ? !m_open[b] : (kind == 2 || kind == 3) ? m_open[b] : 1'b1;
                if (kind != 0 && !legal) begin v = 1; kind = 0; end
                else if (kind != 0) begin
                    s = 1; eb = b; ea = a;
                    if (kind == 1) begin m_open[b] = 1; m_row[b] = a; end
                    if (kind == 2 || kind == 3) begin
                        ap = a[10]; r = m_row[b]; acc = 1;
                        if (a[10]) m_open[b] = 0;
                    end
                    if (kind == 4) begin
                        ap = a[10];
                        if (a[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
                        else m_open[b] = 0;
                    end
                    if (kind == 6) m = b;
                end
            end
        end else if (k) begin
            m_pwr = 0;
        end
        if (acc) m_busy = 4;
        else if (m_busy > 0) m_busy--;
        exp_q.push_back(pack(s, kind, eb, ea, ap, r, m, v, m_open_vec(), 2'(m_pwr)));
        tag_q.push_back(tag);
    endtask

    // monitor: compares after every rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [43:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, pack(cmd_stb, cmd_kind, cmd_bank, cmd_addr, cmd_ap, acc_row,
                          mr_sel, viol, bank_open, pwr_state), e);
        end
    end

    localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                           C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000,
                           C_NOP = 4'b0111, C_RSV = 4'b0110;

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        check("R12 reset state", pack(cmd_stb, cmd_kind, cmd_bank, cmd_addr, cmd_ap,
              acc_row, mr_sel, viol, bank_open, pwr_state), '0);
        @(negedge clk); rst = 1'b0;

        issue(1, C_NOP, 0, 14'h0000, "R3 no-op");
        issue(1, 4'b1011, 1, 14'h0123, "R2 cs_n high masks activate");
        issue(1, C_ACT, 1, 14'h1234, "R4 activate bank1 (R1 registered)");
        issue(1, C_ACT, 1, 14'h0055, "R11 activate to open bank");
        issue(1, C_RD,  1, 14'h0008, "R5 read reports stored row");
        issue(1, C_RD,  2, 14'h0010, "R11 read to idle bank");
        issue(1, C_WR,  1, 14'h040C, "R5 write with auto-precharge");
        issue(0, C_NOP, 0, 14'h0000, "R10 cke drop during access");
        issue(1, C_NOP, 0, 14'h0000, "R10 drain");
        issue(1, C_NOP, 0, 14'h0000, "R10 drain");
        issue(1, C_NOP, 0, 14'h0000, "R10 drain");
        issue(1, C_WR,  1, 14'h0001, "R11 write to bank closed by auto-precharge");
        issue(1, C_ACT, 0, 14'h0100, "R4 activate bank0");
        issue(1, C_ACT, 3, 14'h3FFF, "R4 activate bank3");
        issue(1, C_PRE, 0, 14'h0000, "R6 precharge single bank0");
        issue(1, C_MRS, 2, 14'h00A5, "R7 mode-set extended register 2");
        issue(1, C_MRS, 0, 14'h0432, "R7 mode-set main register");
        issue(1, C_REF, 0, 14'h0000, "R3 refresh");
        issue(1, C_RSV, 1, 14'h0000, "R3 reserved code as no-op");
        issue(0, C_NOP, 0, 14'h0000, "R8 active power-down entry");
        issue(0, C_ACT, 2, 14'h0222, "R9 command ignored in power-down");
        issue(1, C_PRE, 0, 14'h0400, "R9 exit edge command ignored");
        issue(1, C_RD,  3, 14'h0005, "R9 row survived power-down");
        issue(1, C_PRE, 0, 14'h0400, "R6 precharge all banks");
        issue(1, C_NOP, 0, 14'h0000, "R10 drain");
        issue(1, C_NOP, 0, 14'h0000, "R10 drain");
        issue(1, C_NOP, 0, 14'h0000, "R10 drain");
        issue(0, C_NOP, 0, 14'h0000, "R8 precharge power-down entry");
        issue(0, C_NOP, 0, 14'h0000, "R9 stay in power-down");
        issue(1, C_NOP, 0, 14'h0000, "R9 exit to running");
        issue(1, C_ACT, 2, 14'h0777, "R4 activate bank2 before reset");
        issue(1, C_NOP, 0, 14'h0000, "R1 idle");
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        check("R12 mid-run reset clears banks", pack(cmd_stb, cmd_kind, cmd_bank,
              cmd_addr, cmd_ap, acc_row, mr_sel, viol, bank_open, pwr_state), '0);
        @(negedge clk); rst = 1'b0;
        model_reset();
        issue(1, C_RD, 2, 14'h0000, "R12 bank idle after reset");
        repeat (3) @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule